// File: doc/BRIEF.md
# Edge-Reseeded Phase Accumulator Clock Recovery

This block pulls a bit clock and retimed data out of a serial NRZ line that is sampled by a much faster local clock. A phase accumulator adds a programmable step to itself on every fast-clock cycle. Its top bit serves directly as the recovered clock. The ratio of the step to the accumulator range sets the recovered frequency. For example, a step of 0x1000_0000 in a 32-bit accumulator gives one recovered period per 16 fast cycles. With a 160 MHz fast clock, one step LSB is worth about 37.25 mHz.

The phase is not steered by a loop filter. Any change of level on the line, rising or falling, forces the accumulator back to a programmable start value. After that the phase free-runs until the next change of level. When the start value is zero, the top bit rises half a bit after the transition, and the line is sampled at that instant. Alignment drifts while the line holds one level. A flag therefore reports a run without transitions that has lasted longer than the block can tolerate.

Top module: `nrz_edge_nco_cdr`

## Requirements
- R1: While `rst_n` is low, `rec_clk`, `sample_stb`, `data_out` and `run_overflow` are all 0.
- R2: `serial_in` passes through two synchronizing flops and an edge register. A change of level is applied to the accumulator on the third rising clock edge after the change. `rec_clk` does not change before that edge.
- R3: In a cycle without a detected transition, the accumulator adds `tune_word` modulo 2^ACC_W. `rec_clk` is the accumulator MSB. With `tune_word` = 0x1000_0000, `rec_clk` rises exactly 10 times in 160 cycles.
- R4: A rising transition and a falling transition both load `seed_word` into the accumulator. A seed with its MSB set therefore makes `rec_clk` read 1 on the reseed edge, and a zero seed makes it read 0.
- R5: `sample_stb` is high for exactly one cycle for each 0-to-1 step of `rec_clk`, in the first cycle in which `rec_clk` reads 1.
- R6: On the clock edge that ends a strobe cycle, `data_out` takes the synchronized line value. Otherwise `data_out` holds. With a zero seed and a matching `tune_word`, every transmitted bit is sampled once, in order.
- R7: `tune_word` is sampled on every cycle. A new value changes the accumulator on the very next clock edge. A value of 0 freezes `rec_clk`.
- R8: `run_overflow` is 1 when the number of strobes since the last transition exceeds MAX_RUN (default 8). With MAX_RUN = 8, a count of 8 strobes leaves the flag low and a count of 9 raises it.
- R9: A detected transition clears the run count on the next edge. It has priority over a strobe in the same cycle, so `run_overflow` is 0 in the cycle after the transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| serial_in | input | 1 | Asynchronous NRZ line |
| tune_word | input | ACC_W | Phase step added every cycle |
| seed_word | input | ACC_W | Value loaded on each line transition |
| rec_clk | output | 1 | Recovered clock (accumulator MSB) |
| sample_stb | output | 1 | One-cycle pulse at the sampling point |
| data_out | output | 1 | Retimed data bit |
| run_overflow | output | 1 | Run without transitions exceeds MAX_RUN strobes |

## Verification
A detected transition and a sampling strobe can fall in the same cycle. When they do, the transition must clear the run count in preference to the strobe's increment, and the strobe must capture the new line level. The bench first lets a long run raise `run_overflow`. It then waits for one strobe and toggles the line so that the synchronized edge arrives exactly one recovered period later. In the cycle where it expects the coincidence, it checks that `sample_stb` is high. One cycle later it requires the flag to be low and `data_out` to show the new level.

// File: rtl/nrz_edge_nco_cdr.sv
module nrz_edge_nco_cdr #(
  parameter int ACC_W       = 32,
  parameter int MAX_RUN     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             serial_in,
  input  logic [ACC_W-1:0] tune_word,
  input  logic [ACC_W-1:0] seed_word,
  output logic             rec_clk,
  output logic             sample_stb,
  output logic             data_out,
  output logic             run_overflow
);

  localparam int RUN_W = $clog2(MAX_RUN + 2);
  localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(MAX_RUN);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line;
  logic                   prev_q;
  logic                   edge_hit;
  logic [ACC_W-1:0]       acc_q;
  logic                   msb_q;
  logic                   data_q;
  logic [RUN_W-1:0]       run_q;

  assign line       = sync_q[SYNC_STAGES-1];
  assign edge_hit   = line ^ prev_q;
  assign rec_clk    = acc_q[ACC_W-1];
  assign sample_stb = rec_clk & ~msb_q;
  assign data_out   = data_q;
  assign run_overflow = run_q > RUN_LIM;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], serial_in};
      prev_q <= line;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      msb_q <= 1'b0;
    end else begin
      acc_q <= edge_hit ? seed_word : acc_q + tune_word;
      msb_q <= rec_clk;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          data_q <= 1'b0;
    else if (sample_stb) data_q <= line;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                           run_q <= '0;
    else if (edge_hit)                    run_q <= '0;
    else if (sample_stb && !run_overflow) run_q <= run_q + 1'b1;
  end

endmodule

// File: rtl/nrz_cdr_checker.sv
module nrz_cdr_checker #(
  parameter int ACC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             edge_hit,
  input logic [ACC_W-1:0] acc,
  input logic [ACC_W-1:0] tune,
  input logic [ACC_W-1:0] seed,
  input logic             sample_stb,
  input logic             data_out,
  input logic             run_overflow
);

  AST_RESEED_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(edge_hit)) |-> (acc == $past(seed))); // R4

  AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(edge_hit)) |-> (acc == $past(acc) + $past(tune))); // R3

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb); // R5

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> $stable(data_out)); // R6

  AST_OVF_NEEDS_STB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_overflow) |-> $past(sample_stb)); // R8

  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> !run_overflow); // R9

endmodule

bind nrz_edge_nco_cdr nrz_cdr_checker #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .edge_hit(edge_hit), .acc(acc_q),
  .tune(tune_word), .seed(seed_word), .sample_stb(sample_stb),
  .data_out(data_out), .run_overflow(run_overflow)
);

// File: tb/test_nrz_edge_nco_cdr.sv
`timescale 1ns/1ps
module test_nrz_edge_nco_cdr;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, serial_in;
  logic [31:0] tune_word, seed_word;
  logic        rec_clk, sample_stb, data_out, run_overflow;

  nrz_edge_nco_cdr i_nrz_edge_nco_cdr (
    .clk(clk), .rst_n(rst_n), .serial_in(serial_in), .tune_word(tune_word),
    .seed_word(seed_word), .rec_clk(rec_clk), .sample_stb(sample_stb),
    .data_out(data_out), .run_overflow(run_overflow)
  );

  int   checks = 0, errors = 0;
  int   rises, stbs;
  logic prev_rc, mon_exp, ovf_seen;
  logic mon_en = 1'b0;
  logic exp_q[$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [31:0] bits, input int n, input int cyc);
    for (int i = 0; i < n; i++) begin
      serial_in = bits[i];
      exp_q.push_back(bits[i]);
      if (i == 0) begin
        repeat (4) @(negedge clk);
        mon_en = 1'b1;
        repeat (cyc - 4) @(negedge clk);
      end else begin
        repeat (cyc) @(negedge clk);
      end
    end
    mon_en = 1'b0;
    check(exp_q.size() == 0, "R6 all bits sampled", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && sample_stb) begin
        @(posedge clk);
        #1;
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 extra strobe", data_out, 0);
        end else begin
          mon_exp = exp_q.pop_front();
          check(data_out == mon_exp, "R6 retimed bit", data_out, mon_exp);
        end
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; serial_in = 1'b0; tune_word = 32'h1000_0000; seed_word = 32'h0;
    repeat (3) @(negedge clk);
    check(rec_clk == 0, "R1 rec_clk", rec_clk, 0);
    check(sample_stb == 0, "R1 sample_stb", sample_stb, 0);
    check(data_out == 0, "R1 data_out", data_out, 0);
    check(run_overflow == 0, "R1 run_overflow", run_overflow, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    send_frame(32'b0111_0100_1101, 12, 16);
    tune_word = 32'h2000_0000;
    send_frame(32'b01_1000_1011, 10, 8);
    tune_word = 32'h1000_0000;
    send_frame(32'b01_1111_1111, 10, 16);

    // R3 / R5: recovered clock rate and strobe count with the line held low
    rises = 0; stbs = 0;
    @(negedge clk);
    prev_rc = rec_clk;
    for (int i = 0; i < 160; i++) begin
      @(negedge clk);
      if (rec_clk && !prev_rc) rises++;
      if (sample_stb) stbs++;
      prev_rc = rec_clk;
    end
    check(rises == 10, "R3 rec_clk rises", rises, 10);
    check(stbs == 10, "R5 strobes per period", stbs, 10);

    // R2 / R4: reseed latency and both polarities, tune frozen at zero
    tune_word = 32'h0; seed_word = 32'h0;
    serial_in = 1'b1;
    repeat (6) @(negedge clk);
    check(rec_clk == 0, "R4 zero seed after rise", rec_clk, 0);
    seed_word = 32'h8000_0000;
    serial_in = 1'b0;
    repeat (2) @(negedge clk);
    check(rec_clk == 0, "R2 no change before third edge", rec_clk, 0);
    @(negedge clk);
    check(rec_clk == 1, "R4 falling edge loads seed", rec_clk, 1);
    seed_word = 32'h0;
    serial_in = 1'b1;
    repeat (2) @(negedge clk);
    check(rec_clk == 1, "R2 no change before third edge", rec_clk, 1);
    @(negedge clk);
    check(rec_clk == 0, "R4 rising edge loads seed", rec_clk, 0);

    // R7: tune of zero freezes, new tune applies on the next edge
    seed_word = 32'h7FFF_FFF0;
    serial_in = 1'b0;
    repeat (4) @(negedge clk);
    stbs = 0; ovf_seen = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (sample_stb) stbs++;
      if (rec_clk) ovf_seen = 1'b1;
    end
    check(stbs == 0 && !ovf_seen, "R7 zero tune freezes", {stbs[30:0], ovf_seen}, 0);
    tune_word = 32'h10;
    @(negedge clk);
    check(rec_clk == 1, "R7 new tune on next edge", rec_clk, 1);
    check(sample_stb == 1, "R5 strobe on first high cycle", sample_stb, 1);
    @(negedge clk);
    check(sample_stb == 0, "R5 strobe lasts one cycle", sample_stb, 0);

    // R8: run of 8 strobes keeps flag low, 9 raises it
    tune_word = 32'h1000_0000; seed_word = 32'h0;
    serial_in = 1'b1;
    repeat (4) @(negedge clk);
    ovf_seen = 1'b0;
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      if (run_overflow) ovf_seen = 1'b1;
    end
    check(!ovf_seen, "R8 eight strobes no flag", ovf_seen, 0);
    serial_in = 1'b0;
    repeat (150) @(negedge clk);
    check(run_overflow == 1, "R8 nine strobes raise flag", run_overflow, 1);

    // R9: transition coinciding with a strobe
    for (int i = 0; i < 40 && !sample_stb; i++) @(negedge clk);
    repeat (14) @(negedge clk);
    check(run_overflow == 1, "R8 flag held before edge", run_overflow, 1);
    serial_in = 1'b1;
    repeat (2) @(negedge clk);
    check(sample_stb == 1, "R9 strobe in edge cycle", sample_stb, 1);
    @(negedge clk);
    check(run_overflow == 0, "R9 edge wins over strobe", run_overflow, 0);
    check(data_out == 1, "R9 strobe takes new level", data_out, 1);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule